// File: doc/BRIEF.md
# Banked Memory Window Address Translator

This block turns a narrow CPU address into a wider extended address. A configurable window in the CPU address space shows one page of a larger memory: an address inside the window is rebased to the window start, offset by the page number shifted by a configured amount and moved by a virtual base. An address outside the window passes through unchanged, zero-extended. The block also derives two base addresses from an 8-bit placement register: one for the I/O block and one for internal RAM.

Configuration goes through a plain write port (select, data, write enable). Lookups use a valid/ready stream. The request side is always ready and has no back-pressure. The result side presents a registered result with a valid flag one clock after each accepted request. A result stays on the outputs for exactly one cycle, and the consumer must take it in that cycle. Because nothing holds a result back, the request side never needs to stall.

Top module: `bank_xlate_top`

## Requirements
- R1: After reset the window is empty (start = end = 0), the page is 0, the shift is 0, the virtual base is 0 and the placement register is 0x01. So every lookup passes through, the I/O base is 0x1000 and the RAM base is 0x0000.
- R2: An address A is in the window when start <= A < end. The end bound is exclusive, and a window with end <= start is empty.
- R3: For an address in the window, the result is (A - start) + (page << shift) + vbase, truncated to the extended width.
- R4: For an address outside the window, the result is A zero-extended. The page, shift and vbase have no effect on it.
- R5: `res_valid` rises exactly one clock after a cycle with `req_valid` high, and is low otherwise. `req_ready` is always high. `res_addr` and `res_in_win` belong to the request accepted in the previous cycle.
- R6: `res_in_win` is 1 exactly when the result came from the window path.
- R7: `io_base` equals the low nibble of the placement register in bits 15:12, with zeros below.
- R8: `ram_base` equals the high nibble of the placement register in bits 15:12, with zeros below.
- R9: The configuration write port uses these select codes: 0 start, 1 end, 2 shift (low 4 bits), 3 vbase, 4 page (low 8 bits), 5 placement (low 8 bits). Other codes are ignored. A write in cycle N affects lookups issued from cycle N+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready (always 1) |
| req_addr | input | 16 | CPU address to translate |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_addr | output | 24 | Extended address |
| res_in_win | output | 1 | Result came from the window path |
| io_base | output | 16 | I/O block base address |
| ram_base | output | 16 | Internal RAM base address |

## Verification
The bench builds the block with its default 16-bit CPU address, 24-bit extended address and 8-bit page. It sweeps every address within 4 of both window bounds, and every address in a small window across several pages, shifts and virtual bases. It also sweeps all 256 placement values and sets up empty and inverted windows. These small settings reach both bound edges, the wrap of the extended address sum and the ignored select codes, with each expected value worked out arithmetically in the bench.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_END   = 3'd1,
    SEL_SHIFT = 3'd2,
    SEL_VBASE = 3'd3,
    SEL_PAGE  = 3'd4,
    SEL_PLACE = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs #(
  parameter int CPU_W   = 16,
  parameter int EXT_W   = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int PLACE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [EXT_W-1:0]   wdata,
  output logic [CPU_W-1:0]   win_start,
  output logic [CPU_W-1:0]   win_end,
  output logic [SHIFT_W-1:0] pg_shift,
  output logic [EXT_W-1:0]   vbase,
  output logic [PAGE_W-1:0]  page,
  output logic [PLACE_W-1:0] place
);
  import bank_xlate_pkg::*;

  localparam logic [PLACE_W-1:0] PLACE_RST = PLACE_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_start <= '0;
      win_end   <= '0;
      pg_shift  <= '0;
      vbase     <= '0;
      page      <= '0;
      place     <= PLACE_RST;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_START: win_start <= wdata[CPU_W-1:0];
        SEL_END:   win_end   <= wdata[CPU_W-1:0];
        SEL_SHIFT: pg_shift  <= wdata[SHIFT_W-1:0];
        SEL_VBASE: vbase     <= wdata;
        SEL_PAGE:  page      <= wdata[PAGE_W-1:0];
        SEL_PLACE: place     <= wdata[PLACE_W-1:0];
        default: ;
      endcase
    end
  end

  // R9
  unknown_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel > 3'd5) |=> ($stable(win_start) && $stable(win_end) && $stable(page)
                             && $stable(place) && $stable(vbase) && $stable(pg_shift)));
endmodule

// File: rtl/bank_window_map.sv
module bank_window_map #(
  parameter int CPU_W   = 16,
  parameter int EXT_W   = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic [CPU_W-1:0]   addr,
  input  logic [CPU_W-1:0]   win_start,
  input  logic [CPU_W-1:0]   win_end,
  input  logic [SHIFT_W-1:0] pg_shift,
  input  logic [EXT_W-1:0]   vbase,
  input  logic [PAGE_W-1:0]  page,
  output logic [EXT_W-1:0]   ext_addr,
  output logic               in_win
);
  logic [EXT_W-1:0] offset;
  logic [EXT_W-1:0] page_part;
  logic [EXT_W-1:0] mapped;

  always_comb begin
    in_win    = (addr >= win_start) && (addr < win_end);
    offset    = EXT_W'(addr - win_start);
    page_part = EXT_W'(page) << pg_shift;
    mapped    = offset + page_part + vbase;
    ext_addr  = in_win ? mapped : EXT_W'(addr);
  end
endmodule

// File: rtl/bank_base_decode.sv
module bank_base_decode #(
  parameter int CPU_W   = 16,
  parameter int PLACE_W = 8
) (
  input  logic [PLACE_W-1:0] place,
  output logic [CPU_W-1:0]   io_base,
  output logic [CPU_W-1:0]   ram_base
);
  localparam int NIB = 4;

  always_comb begin
    io_base  = '0;
    ram_base = '0;
    io_base[CPU_W-1 -: NIB]  = place[NIB-1:0];
    ram_base[CPU_W-1 -: NIB] = place[2*NIB-1:NIB];
  end
endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top #(
  parameter int CPU_W   = 16,
  parameter int EXT_W   = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 4,
  parameter int PLACE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [EXT_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CPU_W-1:0] req_addr,
  output logic             res_valid,
  output logic [EXT_W-1:0] res_addr,
  output logic             res_in_win,
  output logic [CPU_W-1:0] io_base,
  output logic [CPU_W-1:0] ram_base
);
  logic [CPU_W-1:0]   win_start, win_end;
  logic [SHIFT_W-1:0] pg_shift;
  logic [EXT_W-1:0]   vbase;
  logic [PAGE_W-1:0]  page;
  logic [PLACE_W-1:0] place;
  logic [EXT_W-1:0]   map_addr;
  logic               map_in;

  bank_cfg_regs #(.CPU_W(CPU_W), .EXT_W(EXT_W), .PAGE_W(PAGE_W),
                  .SHIFT_W(SHIFT_W), .PLACE_W(PLACE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .win_start(win_start), .win_end(win_end), .pg_shift(pg_shift),
    .vbase(vbase), .page(page), .place(place));

  bank_window_map #(.CPU_W(CPU_W), .EXT_W(EXT_W), .PAGE_W(PAGE_W),
                    .SHIFT_W(SHIFT_W)) u_map (
    .addr(req_addr), .win_start(win_start), .win_end(win_end),
    .pg_shift(pg_shift), .vbase(vbase), .page(page),
    .ext_addr(map_addr), .in_win(map_in));

  bank_base_decode #(.CPU_W(CPU_W), .PLACE_W(PLACE_W)) u_base (
    .place(place), .io_base(io_base), .ram_base(ram_base));

  assign req_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_addr   <= '0;
      res_in_win <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_addr   <= map_addr;
        res_in_win <= map_in;
      end
    end
  end

  // R5
  res_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R5
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_in_win) |-> (res_addr == EXT_W'($past(req_addr))));
  // R2
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_end <= win_start) |=> !res_in_win);
endmodule

// File: tb/tb_bank_xlate_top.sv
module tb_bank_xlate_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0;
  logic [23:0] cfg_wdata = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [15:0] req_addr = 0;
  logic res_valid;
  logic [23:0] res_addr;
  logic res_in_win;
  logic [15:0] io_base, ram_base;

  int total = 0;
  int bad = 0;

  int m_start = 0, m_end = 0, m_shift = 0, m_vbase = 0, m_page = 0, m_place = 1;

  always #5 clk = ~clk;

  bank_xlate_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = 24'(data);
    case (sel)
      0: m_start = data & 16'hffff;
      1: m_end = data & 16'hffff;
      2: m_shift = data & 15;
      3: m_vbase = data & 24'hffffff;
      4: m_page = data & 8'hff;
      5: m_place = data & 8'hff;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic look(input int a);
    logic in;
    logic [23:0] e;
    @(negedge clk);
    req_valid = 1; req_addr = 16'(a);
    in = (a >= m_start) && (a < m_end);
    e = in ? 24'((a - m_start) + (m_page << m_shift) + m_vbase) : 24'(a);
    @(negedge clk);
    req_valid = 0;
    chk("R5 valid", {31'd0, res_valid}, 1);
    chk("R2 R6 in_win", {31'd0, res_in_win}, {31'd0, in});
    chk(in ? "R3 addr" : "R4 addr", {8'd0, res_addr}, {8'd0, e});
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 io_base", {16'd0, io_base}, 32'h1000);
    chk("R1 ram_base", {16'd0, ram_base}, 0);
    chk("R1 res_valid", {31'd0, res_valid}, 0);
    chk("R5 req_ready", {31'd0, req_ready}, 1);
    look(16'h0000); look(16'h8000); look(16'hffff);
    // R5 no request -> no valid
    @(negedge clk);
    chk("R5 idle", {31'd0, res_valid}, 0);
    // R2/R3 window bounds sweep
    wr(0, 16'h4000); wr(1, 16'h8000); wr(4, 8'h05); wr(2, 14); wr(3, 24'h100000);
    for (int a = 16'h4000 - 4; a <= 16'h4000 + 4; a++) look(a);
    for (int a = 16'h8000 - 4; a <= 16'h8000 + 4; a++) look(a);
    // R3 small window, many pages/shifts/vbases, incl. wrap
    wr(0, 16'h2000); wr(1, 16'h2010);
    for (int p = 0; p < 256; p += 51)
      for (int s = 0; s < 16; s += 5) begin
        wr(4, p); wr(2, s); wr(3, (p * 24'h3579b) & 24'hffffff);
        for (int a = 16'h1ffe; a <= 16'h2011; a++) look(a);
      end
    wr(3, 24'hfffff0); wr(4, 8'hff); wr(2, 15);
    look(16'h200f); look(16'h2000);
    // R2 empty and inverted windows
    wr(1, 16'h2000); look(16'h2000); look(16'h1fff);
    wr(1, 16'h1000); look(16'h1800); look(16'h2000);
    // R9 ignored select codes leave lookups unchanged
    wr(1, 16'h3000);
    wr(6, 24'h000000); wr(7, 24'hffffff);
    look(16'h2005); look(16'h3000);
    chk("R9 ignore io", {16'd0, io_base}, {16'd0, 4'(m_place), 12'd0});
    // R9 write takes effect on next-cycle lookup (back-to-back)
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'd4; cfg_wdata = 24'h000002;
    @(negedge clk);
    cfg_we = 0; m_page = 2;
    req_valid = 1; req_addr = 16'h2001;
    @(negedge clk);
    req_valid = 0;
    chk("R9 next cycle", {8'd0, res_addr},
        {8'd0, 24'(1 + (2 << m_shift) + m_vbase)});
    // R7/R8 placement sweep
    for (int v = 0; v < 256; v++) begin
      wr(5, v);
      @(negedge clk);
      chk("R7 io_base", {16'd0, io_base}, (v & 15) << 12);
      chk("R8 ram_base", {16'd0, ram_base}, (v >> 4) << 12);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule